// File: doc/BRIEF.md
# Unsigned Accumulator Subtract Unit

This block is the execute stage of a DSP instruction that takes an unsigned 16-bit word from data memory away from a signed 32-bit accumulator. It decodes a 16-bit instruction word. In the direct form it builds the operand address from a 9-bit data page pointer and a 7-bit offset held in the instruction. In the indirect form it uses the value of the auxiliary register named by a 3-bit pointer input. It then asks memory for the operand and waits, for as many cycles as needed, until memory reports the word ready.

When the operand arrives, the unit zero-extends it, subtracts it from the accumulator, and updates two status bits. The carry bit means "no borrow". The overflow flag is sticky. An overflow-mode input selects whether an overflowing result saturates or wraps. Completion raises a one-cycle done pulse and a one-cycle request to advance the program counter by one word. In the indirect form the address-register control fields of the instruction are decoded and held on outputs for a post-modify unit elsewhere; this unit does no post-modify arithmetic. Other instructions load the accumulator through a write port.

Top module: `acc_usub_unit`

## Requirements
- R1: A new operation starts only when `instr_valid` is high in the idle state and `instr[15:8]` equals 8'h66. Any other upper byte leaves `mem_req` low and the accumulator unchanged.
- R2: When `instr[7]` is 0 (direct form), `mem_addr` equals `{dp_ptr, instr[6:0]}`. It is presented from the cycle after the instruction is accepted.
- R3: When `instr[7]` is 1 (indirect form), `mem_addr` equals auxiliary register `ar_sel` from `ar_bank`, where register k sits at bits [16k+15:16k]. The outputs `ind_mode`, `aru_code`, `next_flag` and `next_ar` then hold 1, `instr[6:4]`, `instr[3]` and `instr[2:0]`. In the direct form all four read 0.
- R4: On completion, with `ovm` low, `acc` becomes `acc - {16'h0000, mem_data}` modulo 2^32. The operand is always zero-extended, even when its bit 15 is set.
- R5: On completion, `carry` becomes 1 if the unsigned subtraction gives no borrow (acc >= operand as unsigned values) and 0 if it does.
- R6: Signed overflow is a result whose sign differs from the accumulator's sign while the operand signs differ. With `ovm` high, such a result is replaced by 32'h80000000 after negative overflow or 32'h7FFFFFFF after positive overflow.
- R7: `ov` is set on any overflowing completion and holds until `ov_clr` is asserted in a cycle with no overflowing completion. A non-overflowing completion never clears it.
- R8: `done` and `pc_inc` are high together for exactly one cycle. This is the cycle after the edge at which `mem_rdy` was sampled high while the request was outstanding.
- R9: While `mem_rdy` is low, the request stays outstanding and `acc`, `carry` and `ov` do not change. Each low cycle adds one cycle to the operation.
- R10: While a request is outstanding, `instr_valid` is ignored: `mem_addr` does not change and no second completion occurs.
- R11: Reset (synchronous, active high) clears `acc`, `carry`, `ov`, `mem_req`, `done` and `pc_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word presented for execution |
| instr | input | 16 | Instruction word |
| dp_ptr | input | 9 | Data page pointer (upper direct address bits) |
| ar_sel | input | 3 | Current auxiliary register pointer |
| ar_bank | input | 128 | Eight 16-bit auxiliary register values, register k at bits [16k+15:16k] |
| ovm | input | 1 | Overflow mode: 1 saturates, 0 wraps |
| ov_clr | input | 1 | Clears the sticky overflow flag |
| acc_wr | input | 1 | Accumulator load strobe from other instructions |
| acc_wr_data | input | 32 | Accumulator load value |
| mem_req | output | 1 | Operand read outstanding |
| mem_addr | output | 16 | Operand address |
| mem_rdy | input | 1 | Operand word valid on mem_data |
| mem_data | input | 16 | Operand word |
| acc | output | 32 | Accumulator |
| carry | output | 1 | Carry (no-borrow) status bit |
| ov | output | 1 | Sticky overflow flag |
| done | output | 1 | Operation completed this cycle |
| pc_inc | output | 1 | Advance program counter by one word |
| ind_mode | output | 1 | Indirect form accepted |
| aru_code | output | 3 | Address register update code (indirect) |
| next_flag | output | 1 | Next register flag N (indirect) |
| next_ar | output | 3 | Next auxiliary register number (indirect) |

## Verification
If the operand were sign-extended by mistake, any operand with bit 15 set would show a wrong `acc` and `carry` at the first `done` pulse. The sweep therefore pairs such operands with accumulator values near zero and near both signed limits. A stuck or wrongly cleared overflow flag shows on `ov` at the next completion or clear, and the bench follows it across the whole run. A state machine that leaves the wait state early, or that takes a second instruction while busy, moves `mem_addr`, `done` or `acc` in a cycle where the bench expects them to be stable. The bench checks those outputs every stalled cycle.

// File: rtl/acc_usub_pkg.sv
package acc_usub_pkg;
  localparam logic [7:0] OPC_USUB = 8'h66;

  typedef enum logic {ST_IDLE, ST_WAIT} usub_state_t;

  typedef struct packed {
    logic       ind;
    logic [2:0] aru;
    logic       nflag;
    logic [2:0] nar;
    logic [6:0] ofs;
  } usub_dec_t;
endpackage

// File: rtl/acc_usub_decode.sv
module acc_usub_decode
  import acc_usub_pkg::*;
(
  input  logic        valid,
  input  logic [15:0] instr,
  output logic        hit,
  output usub_dec_t   dec
);
  always_comb begin
    hit       = valid && (instr[15:8] == OPC_USUB);
    dec.ind   = instr[7];
    dec.ofs   = instr[6:0];
    dec.aru   = instr[7] ? instr[6:4] : 3'd0;
    dec.nflag = instr[7] ? instr[3]   : 1'b0;
    dec.nar   = instr[7] ? instr[2:0] : 3'd0;
  end
endmodule

// File: rtl/acc_usub_agen.sv
module acc_usub_agen #(
  parameter int DATA_W = 16,
  parameter int DP_W   = 9,
  parameter int OFS_W  = 7,
  parameter int AR_CNT = 8,
  localparam int SEL_W = $clog2(AR_CNT)
) (
  input  logic                     ind,
  input  logic [DP_W-1:0]          dp,
  input  logic [OFS_W-1:0]         ofs,
  input  logic [SEL_W-1:0]         sel,
  input  logic [AR_CNT*DATA_W-1:0] bank,
  output logic [DATA_W-1:0]        addr
);
  logic [DATA_W-1:0] ar_arr [AR_CNT];

  for (genvar g = 0; g < AR_CNT; g++) begin : g_unpack
    assign ar_arr[g] = bank[g*DATA_W +: DATA_W];
  end

  always_comb begin
    if (ind) addr = ar_arr[sel];
    else     addr = {dp, ofs};
  end
endmodule

// File: rtl/acc_usub_alu.sv
module acc_usub_alu #(
  parameter int ACC_W  = 32,
  parameter int DATA_W = 16,
  localparam int EXT_W = ACC_W - DATA_W
) (
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [DATA_W-1:0] opnd,
  input  logic              sat_en,
  output logic [ACC_W-1:0]  res,
  output logic              no_borrow,
  output logic              ovf
);
  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MAX_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] opx;
  logic [ACC_W:0]   diff;

  always_comb begin
    opx       = {{EXT_W{1'b0}}, opnd};
    diff      = {1'b0, acc_in} - {1'b0, opx};
    no_borrow = ~diff[ACC_W];
    ovf       = (acc_in[ACC_W-1] != opx[ACC_W-1]) &&
                (diff[ACC_W-1] != acc_in[ACC_W-1]);
    if (sat_en && ovf) res = acc_in[ACC_W-1] ? MAX_NEG : MAX_POS;
    else               res = diff[ACC_W-1:0];
  end
endmodule

// File: rtl/acc_usub_unit.sv
module acc_usub_unit
  import acc_usub_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int DATA_W = 16,
  parameter int DP_W   = 9,
  parameter int OFS_W  = 7,
  parameter int AR_CNT = 8,
  localparam int SEL_W = $clog2(AR_CNT)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     instr_valid,
  input  logic [15:0]              instr,
  input  logic [DP_W-1:0]          dp_ptr,
  input  logic [SEL_W-1:0]         ar_sel,
  input  logic [AR_CNT*DATA_W-1:0] ar_bank,
  input  logic                     ovm,
  input  logic                     ov_clr,
  input  logic                     acc_wr,
  input  logic [ACC_W-1:0]         acc_wr_data,
  output logic                     mem_req,
  output logic [DATA_W-1:0]        mem_addr,
  input  logic                     mem_rdy,
  input  logic [DATA_W-1:0]        mem_data,
  output logic [ACC_W-1:0]         acc,
  output logic                     carry,
  output logic                     ov,
  output logic                     done,
  output logic                     pc_inc,
  output logic                     ind_mode,
  output logic [2:0]               aru_code,
  output logic                     next_flag,
  output logic [2:0]               next_ar
);
  localparam logic [ACC_W-1:0] SAT_NEG = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] SAT_POS = {1'b0, {(ACC_W-1){1'b1}}};

  usub_state_t       state;
  logic              hit;
  usub_dec_t         dec;
  logic [DATA_W-1:0] addr_nxt;
  logic [ACC_W-1:0]  alu_res;
  logic              alu_nb;
  logic              alu_ovf;
  logic              complete;

  acc_usub_decode u_dec (
    .valid (instr_valid),
    .instr (instr),
    .hit   (hit),
    .dec   (dec)
  );

  acc_usub_agen #(
    .DATA_W (DATA_W),
    .DP_W   (DP_W),
    .OFS_W  (OFS_W),
    .AR_CNT (AR_CNT)
  ) u_agen (
    .ind  (dec.ind),
    .dp   (dp_ptr),
    .ofs  (dec.ofs[OFS_W-1:0]),
    .sel  (ar_sel),
    .bank (ar_bank),
    .addr (addr_nxt)
  );

  acc_usub_alu #(
    .ACC_W  (ACC_W),
    .DATA_W (DATA_W)
  ) u_alu (
    .acc_in    (acc),
    .opnd      (mem_data),
    .sat_en    (ovm),
    .res       (alu_res),
    .no_borrow (alu_nb),
    .ovf       (alu_ovf)
  );

  assign complete = (state == ST_WAIT) && mem_rdy;

  // Sequencer: accept, wait for operand, finish
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      done      <= 1'b0;
      pc_inc    <= 1'b0;
      ind_mode  <= 1'b0;
      aru_code  <= '0;
      next_flag <= 1'b0;
      next_ar   <= '0;
    end else begin
      done   <= 1'b0;
      pc_inc <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (hit) begin
            state     <= ST_WAIT;
            mem_req   <= 1'b1;
            mem_addr  <= addr_nxt;
            ind_mode  <= dec.ind;
            aru_code  <= dec.aru;
            next_flag <= dec.nflag;
            next_ar   <= dec.nar;
          end
        end
        ST_WAIT: begin
          if (mem_rdy) begin
            state   <= ST_IDLE;
            mem_req <= 1'b0;
            done    <= 1'b1;
            pc_inc  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Accumulator and status bits
  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      carry <= 1'b0;
      ov    <= 1'b0;
    end else begin
      if (complete)    acc <= alu_res;
      else if (acc_wr) acc <= acc_wr_data;
      if (complete) carry <= alu_nb;
      if (complete && alu_ovf) ov <= 1'b1;
      else if (ov_clr)         ov <= 1'b0;
    end
  end

  // R1
  start_opc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(instr_valid && instr[15:8] == OPC_USUB));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !mem_rdy && !acc_wr) |=> ($stable(acc) && $stable(carry) && mem_req));

  // R8
  done_pc_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (pc_inc && $past(mem_req && mem_rdy)));

  // R7
  ov_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ov && !ov_clr) |=> ov);

  // R5
  carry_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    complete |=> (carry == ($past(acc) >= {{(ACC_W-DATA_W){1'b0}}, $past(mem_data)})));

  // R6
  sat_value_chk: assert property (@(posedge clk) disable iff (rst)
    (complete && ovm && alu_ovf) |=> (acc == SAT_NEG || acc == SAT_POS));

  // R10
  busy_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !mem_rdy) |=> $stable(mem_addr));
endmodule

// File: tb/sim_acc_usub_unit.sv
module sim_acc_usub_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         instr_valid;
  logic [15:0]  instr;
  logic [8:0]   dp_ptr;
  logic [2:0]   ar_sel;
  logic [127:0] ar_bank;
  logic         ovm, ov_clr, acc_wr;
  logic [31:0]  acc_wr_data;
  logic         mem_req;
  logic [15:0]  mem_addr;
  logic         mem_rdy;
  logic [15:0]  mem_data;
  logic [31:0]  acc;
  logic         carry, ov, done, pc_inc, ind_mode, next_flag;
  logic [2:0]   aru_code, next_ar;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [31:0] m_acc;
  logic        m_carry, m_ov;

  always #4 clk = ~clk;

  acc_usub_unit u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .dp_ptr(dp_ptr), .ar_sel(ar_sel), .ar_bank(ar_bank), .ovm(ovm),
    .ov_clr(ov_clr), .acc_wr(acc_wr), .acc_wr_data(acc_wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy),
    .mem_data(mem_data), .acc(acc), .carry(carry), .ov(ov), .done(done),
    .pc_inc(pc_inc), .ind_mode(ind_mode), .aru_code(aru_code),
    .next_flag(next_flag), .next_ar(next_ar)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_acc(input logic [31:0] v);
    @(negedge clk);
    acc_wr = 1'b1; acc_wr_data = v;
    @(negedge clk);
    acc_wr = 1'b0;
    m_acc = v;
  endtask

  // Issue one operation, stall for 'waits' cycles, then return the operand.
  task automatic do_op(input logic [15:0] iw, input logic [15:0] op,
                       input logic sat, input int waits,
                       input logic [15:0] exp_addr, input logic poke);
    logic [32:0] d;
    logic [31:0] res;
    logic        ovf;
    @(negedge clk);
    instr_valid = 1'b1; instr = iw; ovm = sat;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(iw[7] ? "R3" : "R2", "mem_addr", 32'(mem_addr), 32'(exp_addr));
    chk("R1", "mem_req after accept", 32'(mem_req), 32'd1);
    chk("R3", "ind_mode", 32'(ind_mode), 32'(iw[7]));
    chk("R3", "ctrl fields", {25'd0, aru_code, next_flag, next_ar},
        iw[7] ? {25'd0, iw[6:0]} : 32'd0);
    for (int w = 0; w < waits; w++) begin
      if (poke) begin instr_valid = 1'b1; instr = 16'h6600 | 16'(w + 5); end
      @(negedge clk);
      instr_valid = 1'b0;
      chk("R9", "acc during stall", acc, m_acc);
      chk("R9", "done during stall", {30'd0, done, mem_req}, 32'd1);
      if (poke) chk("R10", "mem_addr while busy", 32'(mem_addr), 32'(exp_addr));
    end
    mem_rdy = 1'b1; mem_data = op;
    @(negedge clk);
    mem_rdy = 1'b0; mem_data = 16'hxxxx;
    d = {1'b0, m_acc} - {17'd0, op};
    res = d[31:0];
    ovf = m_acc[31] && !res[31];
    if (ovf && sat) res = m_acc[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    m_acc = res;
    m_carry = ~d[32];
    m_ov = m_ov | ovf;
    chk(sat ? "R6" : "R4", "acc result", acc, m_acc);
    chk("R5", "carry", 32'(carry), 32'(m_carry));
    chk("R7", "ov", 32'(ov), 32'(m_ov));
    chk("R8", "done/pc_inc pulse", {30'd0, done, pc_inc}, 32'd3);
    @(negedge clk);
    chk("R8", "done/pc_inc after pulse", {30'd0, done, pc_inc}, 32'd0);
    if (poke) chk("R10", "no second request", 32'(mem_req), 32'd0);
  endtask

  logic [31:0] accv [9] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                            32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_FFFF,
                            32'h1234_5678, 32'h8000_7FFE};
  logic [15:0] opv [6] = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr = 16'h0; dp_ptr = 9'h0; ar_sel = 3'd0;
    ovm = 1'b0; ov_clr = 1'b0; acc_wr = 1'b0; acc_wr_data = 32'h0;
    mem_rdy = 1'b0; mem_data = 16'h0;
    for (int k = 0; k < 8; k++) ar_bank[k*16 +: 16] = 16'hA000 + 16'(k * 16'h111);
    m_acc = 32'h0; m_carry = 1'b0; m_ov = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "acc reset", acc, 32'h0);
    chk("R11", "flags reset", {27'd0, carry, ov, mem_req, done, pc_inc}, 32'd0);
    rst = 1'b0;

    // R1 non-matching upper bytes
    for (int b = 0; b < 256; b++) begin
      if (b == 8'h66) continue;
      @(negedge clk);
      instr_valid = 1'b1; instr = {8'(b), 8'h25};
      @(negedge clk);
      instr_valid = 1'b0;
      chk("R1", "no request for other opcode", 32'(mem_req), 32'd0);
    end
    chk("R1", "acc untouched by other opcodes", acc, 32'h0);

    // R4 R5 R6 sweep: accumulator x operand x overflow mode
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 9; a++)
        for (int o = 0; o < 6; o++) begin
          load_acc(accv[a]);
          dp_ptr = 9'(a * 37 + o);
          do_op(16'h6600 | 16'(o * 19), opv[o], s[0], (a + o) % 3,
                {9'(a * 37 + o), 7'(o * 19)}, 1'b0);
        end

    // R7 clear, then stickiness across a non-overflowing op
    @(negedge clk); ov_clr = 1'b1;
    @(negedge clk); ov_clr = 1'b0; m_ov = 1'b0;
    chk("R7", "ov cleared", 32'(ov), 32'd0);
    load_acc(32'h8000_0000);
    do_op(16'h6601, 16'h0001, 1'b0, 0, {dp_ptr, 7'h01}, 1'b0);
    chk("R7", "ov set on overflow", 32'(ov), 32'd1);
    load_acc(32'h0000_0100);
    do_op(16'h6602, 16'h0001, 1'b0, 0, {dp_ptr, 7'h02}, 1'b0);
    chk("R7", "ov held after clean op", 32'(ov), 32'd1);

    // R2 direct address sweep
    for (int p = 0; p < 3; p++) begin
      dp_ptr = (p == 0) ? 9'h000 : (p == 1) ? 9'h155 : 9'h1FF;
      for (int f = 0; f < 128; f += 3)
        do_op(16'h6600 | 16'(f), 16'(f), 1'b0, 0, {dp_ptr, 7'(f)}, 1'b0);
    end

    // R3 indirect: every pointer and every control field value
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 128; c += 9) begin
        ar_sel = 3'(r);
        do_op(16'h6680 | 16'(c ^ r), 16'hC000 | 16'(c), 1'b1, r % 2,
              16'hA000 + 16'(r * 16'h111), 1'b0);
      end

    // R10 instructions offered while busy
    load_acc(32'h0001_0000);
    dp_ptr = 9'h0AA;
    do_op(16'h6633, 16'h0010, 1'b0, 4, {9'h0AA, 7'h33}, 1'b1);

    // R11 reset mid-operation
    @(negedge clk); instr_valid = 1'b1; instr = 16'h6611;
    @(negedge clk); instr_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R11", "reset clears request", {29'd0, mem_req, done, pc_inc}, 32'd0);
    chk("R11", "reset clears acc", acc, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule